// File: doc/BRIEF.md
# Parallel Switch Layer-Selection Demultiplexor

This block is the input-side dispatcher of a parallel packet switch. The fabric is built from several identical, slower output-queued switches (layers) working side by side. Each external input delivers at most one cell per time slot. For every arriving cell, the dispatcher names the layer that will carry it and the slot in which it will leave. The intent is that the whole fabric behaves like one fast first-in first-out output-queued switch.

Each internal link runs at a fraction of the line rate, so a cell occupies its input-to-layer link, and later its layer-to-output link, for HOLD = ceil(N_LAYERS / SPEEDUP) slots. The dispatcher keeps three pieces of state:
- a shadow departure counter per output, which gives each cell the slot it would leave a line-rate FIFO output-queued switch;
- occupancy counters for every input-to-layer link;
- a ledger of the most recent departure slot booked on each layer for each output.

A layer qualifies for a cell only when it is free at the input in the current slot and free at the output around the cell's departure slot. Among qualifying layers, the lowest-numbered one wins. With the default sizing (4 ports, 6 layers, speedup 3), HOLD is 2. At least 5 layers are then free on each side, so the intersection always holds at least 4 layers and is never empty.

The slot counter starts at 0 in the first cycle after reset and advances by one each clock. One clock is one time slot.

Top module: `pps_layer_dispatch`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every bit of `gnt_valid_o` is 0 and `empty_err_o` is 0.
- R2: Arrivals are sampled in slot n. In the cycle after the edge that ends slot n, bit i of `gnt_valid_o` is 1 exactly when input i had a cell in slot n.
- R3: After an input sends a cell on a layer, that input does not use the same layer again for the next HOLD-1 slots (1 slot by default). The layer becomes usable again HOLD slots after the grant.
- R4: A cell arriving in slot n for output j gets departure slot d = max(next_dep[j], n), and next_dep[j] then becomes d+1. A cell for an output with no backlog departs in its arrival slot. The departure is reported on the cell's field of `gnt_dep_o` (bits i*16 +: 16).
- R5: When several inputs send to the same output in one slot, they are handled in ascending input index. Their departure slots are consecutive in that order.
- R6: For any output, two cells placed on the same layer have departure slots at least HOLD apart.
- R7: Among layers that satisfy both R3 and R6, the lowest-numbered layer is chosen. It is reported as a 3-bit field of `gnt_layer_o` at bits i*3 +: 3.
- R8: For every arrival pattern with the default parameters, each arriving cell receives a layer below N_LAYERS, and `empty_err_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one time slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| arr_valid_i | input | N_PORTS | Cell present at each input in this slot |
| arr_dest_i | input | N_PORTS*PW | Destination output for each input; field i at bits i*PW +: PW |
| gnt_valid_o | output | N_PORTS | Registered: a layer was assigned to input i's cell from the previous slot |
| gnt_layer_o | output | N_PORTS*LW | Registered: chosen layer for each input |
| gnt_dep_o | output | N_PORTS*16 | Registered: departure slot of each granted cell |
| empty_err_o | output | 1 | Registered: some arrival in the previous slot found no qualifying layer |

## Verification
The bench targets these corner cases:
- Back-to-back cells from one input. A design that released the input link too early, or too late, would pick the wrong layer in the second and third slots.
- Several inputs hitting one output in the same slot. This exposes a design that read stale departure counters instead of chaining them in input order: it would give duplicate departure slots or stack cells on one layer.
- Sustained overload of one output. This builds a deep backlog, so departure slots run far ahead of the current slot, and it tests the output-side spacing of reservations.
- A long idle gap. The departure counter must fall back to the current slot; a design that kept counting from a stale value would report late departures.
- A long random run. This confirms that the choice set never empties and that the lowest-layer priority holds under mixed traffic.

// File: rtl/pps_disp_pkg.sv
package pps_disp_pkg;

  localparam int SLOT_W = 16;
  typedef logic [SLOT_W-1:0] slot_t;

  // a is at or after b, wrap-safe within half the slot range
  function automatic logic slot_at_or_after(slot_t a, slot_t b);
    slot_t diff;
    diff = a - b;
    return !diff[SLOT_W-1];
  endfunction

  // departure slot of a new cell: later of the output's next free slot and now
  function automatic slot_t depart_slot(slot_t next_free, slot_t now);
    return slot_at_or_after(next_free, now) ? next_free : now;
  endfunction

  // a reservation at 'newer' does not overlap one at 'older' of length hold
  function automatic logic spaced_apart(slot_t newer, slot_t older, int hold);
    slot_t diff;
    diff = newer - older;
    return diff >= slot_t'(hold);
  endfunction

  // a reservation at 'booked' is fully in the past relative to 'now'
  function automatic logic booking_done(slot_t booked, slot_t now, int hold);
    slot_t diff;
    diff = now - booked;
    return !diff[SLOT_W-1] && (diff >= slot_t'(hold));
  endfunction

endpackage

// File: rtl/pps_in_links.sv
module pps_in_links #(
  parameter int N_PORTS  = 4,
  parameter int N_LAYERS = 6,
  parameter int HOLD     = 2,
  parameter int LW       = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [N_PORTS-1:0]               take_vld,
  input  logic [N_PORTS-1:0][LW-1:0]       take_layer,
  output logic [N_PORTS-1:0][N_LAYERS-1:0] link_free
);

  localparam int HW = (HOLD > 1) ? $clog2(HOLD + 1) : 1;

  for (genvar i = 0; i < N_PORTS; i++) begin : g_in
    for (genvar l = 0; l < N_LAYERS; l++) begin : g_lay
      logic [HW-1:0] busy_cnt;
      logic          take_here;

      assign take_here       = take_vld[i] && (take_layer[i] == LW'(l));
      assign link_free[i][l] = (busy_cnt == '0);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          busy_cnt <= '0;
        end else if (take_here) begin
          busy_cnt <= HW'(HOLD - 1);
        end else if (busy_cnt != '0) begin
          busy_cnt <= busy_cnt - 1'b1;
        end
      end

      AST_IN_LINK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        take_here |-> (busy_cnt == '0)); // R3
    end
  end

endmodule

// File: rtl/pps_layer_pick.sv
module pps_layer_pick
  import pps_disp_pkg::*;
#(
  parameter int N_PORTS  = 4,
  parameter int N_LAYERS = 6,
  parameter int HOLD     = 2,
  parameter int LW       = 3,
  parameter int PW       = 2
) (
  input  slot_t                                   slot_n,
  input  logic [N_PORTS-1:0]                      arr_vld,
  input  logic [N_PORTS-1:0][PW-1:0]              arr_dest,
  input  logic [N_PORTS-1:0][N_LAYERS-1:0]        link_free,
  input  slot_t [N_PORTS-1:0]                     nd_q,
  input  slot_t [N_PORTS-1:0][N_LAYERS-1:0]       last_q,
  input  logic  [N_PORTS-1:0][N_LAYERS-1:0]       rv_q,
  output logic [N_PORTS-1:0]                      pick_vld,
  output logic [N_PORTS-1:0][LW-1:0]              pick_layer,
  output slot_t [N_PORTS-1:0]                     pick_dep,
  output logic [N_PORTS-1:0]                      pick_empty,
  output slot_t [N_PORTS-1:0]                     nd_nx,
  output slot_t [N_PORTS-1:0][N_LAYERS-1:0]       last_nx,
  output logic  [N_PORTS-1:0][N_LAYERS-1:0]       rv_nx
);

  // named per-input views of the two availability sets and their meet
  logic [N_PORTS-1:0][N_LAYERS-1:0] out_free_w;
  logic [N_PORTS-1:0][N_LAYERS-1:0] cand_w;
  logic [PW-1:0]                    dst;
  slot_t                            dep;
  logic                             found;
  logic [LW-1:0]                    sel;

  always_comb begin
    nd_nx      = nd_q;
    last_nx    = last_q;
    rv_nx      = rv_q;
    pick_vld   = '0;
    pick_layer = '0;
    pick_dep   = '0;
    pick_empty = '0;
    out_free_w = '0;
    cand_w     = '0;
    dst        = '0;
    dep        = '0;
    found      = 1'b0;
    sel        = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      dst   = arr_dest[i];
      dep   = depart_slot(nd_nx[dst], slot_n);
      found = 1'b0;
      sel   = '0;
      for (int l = 0; l < N_LAYERS; l++) begin
        out_free_w[i][l] = !(rv_nx[dst][l] && !spaced_apart(dep, last_nx[dst][l], HOLD));
      end
      cand_w[i] = link_free[i] & out_free_w[i];
      for (int l = 0; l < N_LAYERS; l++) begin
        if (cand_w[i][l] && !found) begin
          found = 1'b1;
          sel   = LW'(l);
        end
      end
      if (arr_vld[i]) begin
        if (found) begin
          pick_vld[i]        = 1'b1;
          pick_layer[i]      = sel;
          pick_dep[i]        = dep;
          nd_nx[dst]         = dep + 1'b1;
          last_nx[dst][sel]  = dep;
          rv_nx[dst][sel]    = 1'b1;
        end else begin
          pick_empty[i] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pps_out_ledger.sv
module pps_out_ledger
  import pps_disp_pkg::*;
#(
  parameter int N_PORTS  = 4,
  parameter int N_LAYERS = 6,
  parameter int HOLD     = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  slot_t                             slot_n,
  input  slot_t [N_PORTS-1:0]               nd_nx,
  input  slot_t [N_PORTS-1:0][N_LAYERS-1:0] last_nx,
  input  logic  [N_PORTS-1:0][N_LAYERS-1:0] rv_nx,
  output slot_t [N_PORTS-1:0]               nd_q,
  output slot_t [N_PORTS-1:0][N_LAYERS-1:0] last_q,
  output logic  [N_PORTS-1:0][N_LAYERS-1:0] rv_q
);

  slot_t slot_next;
  assign slot_next = slot_n + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nd_q   <= '0;
      last_q <= '0;
      rv_q   <= '0;
    end else begin
      for (int j = 0; j < N_PORTS; j++) begin
        // never let the counter lag the clock: keeps wrap-safe compares valid
        nd_q[j] <= depart_slot(nd_nx[j], slot_next);
        for (int l = 0; l < N_LAYERS; l++) begin
          last_q[j][l] <= last_nx[j][l];
          rv_q[j][l]   <= rv_nx[j][l] && !booking_done(last_nx[j][l], slot_next, HOLD);
        end
      end
    end
  end

  for (genvar j = 0; j < N_PORTS; j++) begin : g_out
    AST_DEP_NO_RETREAT: assert property (@(posedge clk) disable iff (!rst_n)
      $signed(nd_nx[j] - nd_q[j]) >= 0); // R4
    for (genvar l = 0; l < N_LAYERS; l++) begin : g_lay
      AST_OUT_LINK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (rv_q[j][l] && (last_nx[j][l] != last_q[j][l]))
          |-> spaced_apart(last_nx[j][l], last_q[j][l], HOLD)); // R6
    end
  end

endmodule

// File: rtl/pps_layer_dispatch.sv
module pps_layer_dispatch
  import pps_disp_pkg::*;
#(
  parameter  int N_PORTS  = 4,
  parameter  int N_LAYERS = 6,
  parameter  int SPEEDUP  = 3,
  localparam int PW       = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int LW       = (N_LAYERS > 1) ? $clog2(N_LAYERS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PORTS-1:0]        arr_valid_i,
  input  logic [N_PORTS*PW-1:0]     arr_dest_i,
  output logic [N_PORTS-1:0]        gnt_valid_o,
  output logic [N_PORTS*LW-1:0]     gnt_layer_o,
  output logic [N_PORTS*SLOT_W-1:0] gnt_dep_o,
  output logic                      empty_err_o
);

  localparam int HOLD = (N_LAYERS + SPEEDUP - 1) / SPEEDUP;

  slot_t                             slot_q;
  logic  [N_PORTS-1:0][PW-1:0]       dest_w;
  logic  [N_PORTS-1:0][N_LAYERS-1:0] link_free_w;
  slot_t [N_PORTS-1:0]               nd_q, nd_nx;
  slot_t [N_PORTS-1:0][N_LAYERS-1:0] last_q, last_nx;
  logic  [N_PORTS-1:0][N_LAYERS-1:0] rv_q, rv_nx;
  logic  [N_PORTS-1:0]               pick_vld, pick_empty;
  logic  [N_PORTS-1:0][LW-1:0]       pick_layer;
  slot_t [N_PORTS-1:0]               pick_dep;
  logic  [N_PORTS-1:0][LW-1:0]       gnt_layer_q;
  slot_t [N_PORTS-1:0]               gnt_dep_q;
  slot_t                             prev_slot;

  assign dest_w = arr_dest_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_q + 1'b1;
  end

  pps_in_links #(.N_PORTS(N_PORTS), .N_LAYERS(N_LAYERS), .HOLD(HOLD), .LW(LW)) u_in (
    .clk(clk), .rst_n(rst_n),
    .take_vld(pick_vld), .take_layer(pick_layer),
    .link_free(link_free_w)
  );

  pps_layer_pick #(.N_PORTS(N_PORTS), .N_LAYERS(N_LAYERS), .HOLD(HOLD), .LW(LW), .PW(PW)) u_pick (
    .slot_n(slot_q), .arr_vld(arr_valid_i), .arr_dest(dest_w), .link_free(link_free_w),
    .nd_q(nd_q), .last_q(last_q), .rv_q(rv_q),
    .pick_vld(pick_vld), .pick_layer(pick_layer), .pick_dep(pick_dep), .pick_empty(pick_empty),
    .nd_nx(nd_nx), .last_nx(last_nx), .rv_nx(rv_nx)
  );

  pps_out_ledger #(.N_PORTS(N_PORTS), .N_LAYERS(N_LAYERS), .HOLD(HOLD)) u_ledger (
    .clk(clk), .rst_n(rst_n), .slot_n(slot_q),
    .nd_nx(nd_nx), .last_nx(last_nx), .rv_nx(rv_nx),
    .nd_q(nd_q), .last_q(last_q), .rv_q(rv_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_valid_o <= '0;
      gnt_layer_q <= '0;
      gnt_dep_q   <= '0;
      empty_err_o <= 1'b0;
    end else begin
      gnt_valid_o <= pick_vld;
      gnt_layer_q <= pick_layer;
      gnt_dep_q   <= pick_dep;
      empty_err_o <= |pick_empty;
    end
  end

  assign gnt_layer_o = gnt_layer_q;
  assign gnt_dep_o   = gnt_dep_q;
  assign prev_slot   = slot_q - 1'b1;

  AST_NO_EMPTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_err_o); // R8

  for (genvar i = 0; i < N_PORTS; i++) begin : g_chk
    AST_GRANT_HAS_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid_o[i] |-> $past(arr_valid_i[i])); // R2
    AST_LAYER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid_o[i] |-> (gnt_layer_q[i] < LW'(N_LAYERS))); // R8
    AST_DEP_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid_o[i] |-> ($signed(gnt_dep_q[i] - prev_slot) >= 0)); // R4
  end

endmodule

// File: tb/tb_pps_layer_dispatch.sv
module tb_pps_layer_dispatch;

  localparam int N    = 4;
  localparam int K    = 6;
  localparam int S    = 3;
  localparam int HOLD = (K + S - 1) / S;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N-1:0]     arr_valid = '0;
  logic [N*2-1:0]   arr_dest = '0;
  logic [N-1:0]     gnt_valid;
  logic [N*3-1:0]   gnt_layer;
  logic [N*16-1:0]  gnt_dep;
  logic             empty_err;

  always #4 clk = ~clk;  // 125 MHz

  pps_layer_dispatch dut (
    .clk(clk), .rst_n(rst_n),
    .arr_valid_i(arr_valid), .arr_dest_i(arr_dest),
    .gnt_valid_o(gnt_valid), .gnt_layer_o(gnt_layer),
    .gnt_dep_o(gnt_dep), .empty_err_o(empty_err)
  );

  int checks = 0;
  int fails  = 0;
  int tslot  = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) tslot <= 0;
    else        tslot <= tslot + 1;
  end

  // reference state
  int in_free_at [N][K];
  int out_booked [N][K];
  int next_dep   [N];

  typedef struct {
    logic [N-1:0] vld;
    int           layer [N];
    int           dep   [N];
    logic         err;
    string        tag;
  } exp_t;

  exp_t exp_q [$];

  task automatic check(input string tag, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      next_dep[i] = 0;
      for (int l = 0; l < K; l++) begin
        in_free_at[i][l] = 0;
        out_booked[i][l] = -1000;
      end
    end
  endtask

  task automatic drive(input logic [N-1:0] v, input int d0, input int d1,
                       input int d2, input int d3, input string tag);
    exp_t e;
    int   dv [N];
    int   n;
    dv[0] = d0; dv[1] = d1; dv[2] = d2; dv[3] = d3;
    @(negedge clk);
    n = tslot;
    e.vld = '0; e.err = 1'b0; e.tag = tag;
    for (int i = 0; i < N; i++) begin
      e.layer[i] = 0; e.dep[i] = 0;
      arr_dest[i*2 +: 2] = 2'(dv[i]);
      if (v[i]) begin
        int j, dd, pick;
        j    = dv[i];
        dd   = (next_dep[j] > n) ? next_dep[j] : n;
        pick = -1;
        for (int l = K - 1; l >= 0; l--) begin
          if (in_free_at[i][l] <= n && (dd - out_booked[j][l]) >= HOLD) pick = l;
        end
        if (pick < 0) begin
          e.err = 1'b1;
        end else begin
          e.vld[i] = 1'b1;
          e.layer[i] = pick;
          e.dep[i] = dd;
          in_free_at[i][pick] = n + HOLD;
          out_booked[j][pick] = dd;
          next_dep[j] = dd + 1;
        end
      end
    end
    arr_valid = v;
    exp_q.push_back(e);
  endtask

  // monitor: results of slot n are stable shortly after the edge closing slot n
  always @(posedge clk) begin
    #2;
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, "grant mask (R2)", int'(gnt_valid), int'(e.vld));
      check("R8", "empty flag", int'(empty_err), int'(e.err));
      for (int i = 0; i < N; i++) begin
        if (e.vld[i]) begin
          check(e.tag, $sformatf("layer in%0d (R7)", i), int'(gnt_layer[i*3 +: 3]), e.layer[i]);
          check(e.tag, $sformatf("departure in%0d (R4)", i), int'(gnt_dep[i*16 +: 16]), e.dep[i] & 16'hFFFF);
        end
      end
    end
  end

  initial begin
    model_reset();
    fork
      begin
        repeat (3) @(negedge clk);
        check("R1", "grant mask in reset", int'(gnt_valid), 0);
        check("R1", "empty flag in reset", int'(empty_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "grant mask after reset", int'(gnt_valid), 0);
        // idle slots: no grants
        drive(4'b0000, 0, 0, 0, 0, "R2");
        drive(4'b0000, 0, 0, 0, 0, "R2");
        // lone cell to an idle output departs now on layer 0
        drive(4'b0001, 2, 0, 0, 0, "R4");
        // same input next slot: layer 0 still busy at the input
        drive(4'b0001, 1, 0, 0, 0, "R3");
        // one slot later: layer 0 free again at the input
        drive(4'b0001, 3, 0, 0, 0, "R3");
        drive(4'b0000, 0, 0, 0, 0, "R2");
        drive(4'b0000, 0, 0, 0, 0, "R2");
        // all inputs to one output: consecutive departures in index order
        drive(4'b1111, 0, 0, 0, 0, "R5");
        drive(4'b0000, 0, 0, 0, 0, "R2");
        drive(4'b0000, 0, 0, 0, 0, "R2");
        drive(4'b0000, 0, 0, 0, 0, "R2");
        drive(4'b0000, 0, 0, 0, 0, "R2");
        // distinct outputs: every input takes the lowest layer
        drive(4'b1111, 0, 1, 2, 3, "R7");
        drive(4'b1111, 1, 2, 3, 0, "R7");
        // overload one output: backlog grows, reservations must stay spaced
        for (int s = 0; s < 40; s++) drive(4'b1111, 1, 1, 1, 1, "R6");
        // idle long enough to drain the backlog, then departure falls back to now
        for (int s = 0; s < 160; s++) drive(4'b0000, 0, 0, 0, 0, "R2");
        drive(4'b0010, 0, 1, 0, 0, "R4");
        // mixed random traffic: choice set never empties
        for (int s = 0; s < 3000; s++) begin
          logic [N-1:0] v;
          v = 4'($urandom_range(0, 15));
          drive(v, $urandom_range(0, 3), $urandom_range(0, 3),
                $urandom_range(0, 3), $urandom_range(0, 3), "R8");
        end
        drive(4'b0000, 0, 0, 0, 0, "R2");
        drive(4'b0000, 0, 0, 0, 0, "R2");
        repeat (3) @(negedge clk);
      end
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule